// File: doc/BRIEF.md
# Sector Write-Protection Controller

This block keeps the write-protection state of every sector in a large non-volatile memory array. It decides whether a program or erase request may go ahead. Software-level commands act on the protection state. Each sector can be protected or unprotected on its own, all sectors can be protected or unprotected at once, and a sector can be locked down permanently. A hardware write-protect input freezes protected sectors against unprotection. A status query returns the two state bits of any sector.

Protection bits are held in registers cleared to "all protected" by the power-on input `por_n`. Lockdown bits survive a power-on and are cleared only by `nv_clr_n`, which models a blank device. Check requests go to a small state machine with three states.

- `ST_IDLE` waits for a check.
- `ST_SCAN` sweeps the sector state `SCAN_LANES` sectors per cycle for a full-chip erase.
- `ST_DONE` presents the verdict for one cycle.

The transitions are:

- `ST_IDLE`→`ST_DONE` on a sector check.
- `ST_IDLE`→`ST_SCAN` on a chip check.
- `ST_SCAN`→`ST_SCAN` while chunks remain.
- `ST_SCAN`→`ST_DONE` after the last chunk.
- `ST_DONE`→`ST_IDLE` always.

Top module: `sector_guard`

## Requirements
- R1: There are 128 sectors, and the sector index is address bits [22:16]; other address bits are ignored. A single-sector command changes only the sector it addresses.
- R2: `cmd_op` 1 protects the addressed sector. `cmd_op` 2 unprotects it, unless the sector is locked or `hw_wp` is high. Codes 0, 6 and 7 do nothing.
- R3: `cmd_op` 3 makes every sector protected, visible from the next cycle.
- R4: `cmd_op` 4 unprotects every sector that is not locked down; locked sectors stay protected.
- R5: `cmd_op` 5 locks the addressed sector down and protects it. No command and no `por_n` pulse ever clears a lock; only `nv_clr_n` low does.
- R6: While `hw_wp` is high, `cmd_op` 2 and 4 have no effect, but `cmd_op` 1, 3 and 5 are still applied.
- R7: While `por_n` is low, every sector becomes protected and the lock bits keep their values.
- R8: A query on `qry_valid` returns `qry_ack` high in the next cycle, with `qry_stat` bit 1 = locked and bit 0 = protected. A locked sector always reads as protected.
- R9: A check with `chk_kind` 0 (4KB), 1 (32KB) or 2 (64KB) raises `chk_done` one cycle later. `chk_allow` is high only if the addressed sector is unprotected.
- R10: A check with `chk_kind` 3 (whole chip) raises `chk_done` 128/`SCAN_LANES`+1 cycles later. `chk_allow` is high only if no sector is protected.
- R11: While `chk_busy` is high, commands and new checks are ignored.
- R12: `chk_done` is a one-cycle pulse, and `chk_allow` is low whenever `chk_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; sets all sectors protected |
| nv_clr_n | input | 1 | Blank-device clear of lock bits, active low |
| hw_wp | input | 1 | Hardware write-protect, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 24 | Command byte address |
| chk_valid | input | 1 | Check request strobe |
| chk_kind | input | 2 | Check granularity |
| chk_addr | input | 24 | Check byte address |
| chk_busy | output | 1 | Check engine not idle |
| chk_done | output | 1 | Verdict valid pulse |
| chk_allow | output | 1 | Request may proceed |
| qry_valid | input | 1 | Status query strobe |
| qry_addr | input | 24 | Query byte address |
| qry_ack | output | 1 | Query result valid |
| qry_stat | output | 2 | {locked, protected} |

## Verification
The assertions take for granted that `por_n` and `nv_clr_n` are driven low at time zero and released only while no strobe is active. They also assume that strobes are held for exactly one cycle. The stimulus drives every input on the falling clock edge from tasks that raise a strobe for a single cycle. It waits one extra cycle after each `chk_done` before issuing anything new, so that no command is lost to the busy window by accident. The only commands sent while busy are the deliberate ones in the R11 test. Locks are drawn rarely, so the random mix of commands, write-protect levels and checks keeps reaching unlocked sectors.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PROT_ONE = 3'd1,
        OP_UNPR_ONE = 3'd2,
        OP_PROT_ALL = 3'd3,
        OP_UNPR_ALL = 3'd4,
        OP_LOCK_ONE = 3'd5
    } sg_op_e;

    typedef enum logic [1:0] {
        CK_4K   = 2'd0,
        CK_32K  = 2'd1,
        CK_64K  = 2'd2,
        CK_CHIP = 2'd3
    } sg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } sg_state_e;

    typedef struct packed {
        logic locked;
        logic prot;
    } sg_stat_t;

endpackage

// File: rtl/sg_sector_bank.sv
module sg_sector_bank
    import sg_pkg::*;
#(
    parameter int N_SECT = 128,
    parameter int SECT_W = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              nv_clr_n,
    input  logic              hw_wp,
    input  logic              wr_en,
    input  sg_op_e            op,
    input  logic [SECT_W-1:0] sel,
    output logic [N_SECT-1:0] prot_eff,
    output logic [N_SECT-1:0] lock_q
);

    for (genvar i = 0; i < N_SECT; i++) begin : g_sect
        logic hit;
        logic p_q;
        logic p_nx;
        logic l_q;
        logic l_nx;

        assign hit = (sel == SECT_W'(i));

        always_comb begin
            p_nx = p_q;
            l_nx = l_q;
            if (wr_en) begin
                case (op)
                    OP_PROT_ONE: if (hit) p_nx = 1'b1;
                    OP_UNPR_ONE: if (hit && !l_q && !hw_wp) p_nx = 1'b0;
                    OP_PROT_ALL: p_nx = 1'b1;
                    OP_UNPR_ALL: if (!l_q && !hw_wp) p_nx = 1'b0;
                    OP_LOCK_ONE: if (hit) begin
                        p_nx = 1'b1;
                        l_nx = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) p_q <= 1'b1;
            else        p_q <= p_nx;
        end

        always_ff @(posedge clk or negedge nv_clr_n) begin
            if (!nv_clr_n) l_q <= 1'b0;
            else           l_q <= l_nx;
        end

        assign prot_eff[i] = p_q | l_q;
        assign lock_q[i]   = l_q;
    end

endmodule

// File: rtl/sg_check_fsm.sv
module sg_check_fsm
    import sg_pkg::*;
#(
    parameter int N_SECT = 128,
    parameter int SECT_W = $clog2(N_SECT),
    parameter int LANES  = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              start,
    input  logic              chip,
    input  logic [SECT_W-1:0] sel,
    input  logic [N_SECT-1:0] prot_eff,
    output logic              busy,
    output logic              done,
    output logic              allow
);

    localparam int N_CHUNK = N_SECT / LANES;
    localparam int IDX_W   = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CHUNK - 1);

    sg_state_e        state_q, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic             acc_q;
    logic             res_q;
    logic             chunk_any;

    assign chunk_any = |prot_eff[idx_q*LANES +: LANES];

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nx = chip ? ST_SCAN : ST_DONE;
            ST_SCAN: if (idx_q == LAST) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            idx_q <= '0;
            acc_q <= 1'b0;
            res_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    idx_q <= '0;
                    acc_q <= 1'b0;
                    res_q <= !prot_eff[sel];
                end
                ST_SCAN: begin
                    acc_q <= acc_q | chunk_any;
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST) res_q <= !(acc_q | chunk_any);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        done  = (state_q == ST_DONE);
        allow = (state_q == ST_DONE) && res_q;
    end

endmodule

// File: rtl/sector_guard.sv
module sector_guard
    import sg_pkg::*;
#(
    parameter int N_SECT     = 128,
    parameter int ADDR_W     = 24,
    parameter int SECT_LSB   = 16,
    parameter int SCAN_LANES = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              nv_clr_n,
    input  logic              hw_wp,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              chk_valid,
    input  logic [1:0]        chk_kind,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_busy,
    output logic              chk_done,
    output logic              chk_allow,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_ack,
    output logic [1:0]        qry_stat
);

    localparam int SECT_W = $clog2(N_SECT);

    logic [N_SECT-1:0] prot_eff;
    logic [N_SECT-1:0] lock_q;
    logic [SECT_W-1:0] cmd_sel, chk_sel, qry_sel;
    logic              busy;
    sg_stat_t          stat_q;
    logic              ack_q;

    assign cmd_sel = cmd_addr[SECT_LSB +: SECT_W];
    assign chk_sel = chk_addr[SECT_LSB +: SECT_W];
    assign qry_sel = qry_addr[SECT_LSB +: SECT_W];

    sg_sector_bank #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_bank (
        .clk      (clk),
        .por_n    (por_n),
        .nv_clr_n (nv_clr_n),
        .hw_wp    (hw_wp),
        .wr_en    (cmd_valid && !busy),
        .op       (sg_op_e'(cmd_op)),
        .sel      (cmd_sel),
        .prot_eff (prot_eff),
        .lock_q   (lock_q)
    );

    sg_check_fsm #(.N_SECT(N_SECT), .SECT_W(SECT_W), .LANES(SCAN_LANES)) u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .start    (chk_valid && !busy),
        .chip     (sg_kind_e'(chk_kind) == CK_CHIP),
        .sel      (chk_sel),
        .prot_eff (prot_eff),
        .busy     (busy),
        .done     (chk_done),
        .allow    (chk_allow)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ack_q  <= 1'b0;
            stat_q <= '0;
        end else begin
            ack_q <= qry_valid;
            if (qry_valid) begin
                stat_q.locked <= lock_q[qry_sel];
                stat_q.prot   <= prot_eff[qry_sel];
            end
        end
    end

    assign chk_busy = busy;
    assign qry_ack  = ack_q;
    assign qry_stat = stat_q;

endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
    parameter int N_SECT = 128
) (
    input logic              clk,
    input logic              por_n,
    input logic              nv_clr_n,
    input logic              hw_wp,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              chk_busy,
    input logic              chk_done,
    input logic              chk_allow,
    input logic              qry_ack,
    input logic [1:0]        qry_stat,
    input logic [N_SECT-1:0] prot_eff,
    input logic [N_SECT-1:0] lock_q
);

    p_prot_all_r3: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_valid && !chk_busy && cmd_op == 3'd3) |=> (&prot_eff));

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!nv_clr_n)
        (($past(lock_q) & ~lock_q) == '0));

    p_wp_unprot_r6: assert property (@(posedge clk) disable iff (!por_n || !nv_clr_n)
        (hw_wp && cmd_valid && !chk_busy && (cmd_op == 3'd2 || cmd_op == 3'd4))
        |=> $stable(prot_eff));

    p_por_prot_r7: assert property (@(posedge clk)
        $rose(por_n) |-> (&prot_eff));

    p_lock_reads_prot_r8: assert property (@(posedge clk) disable iff (!por_n)
        (qry_ack && qry_stat[1]) |-> qry_stat[0]);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!por_n)
        chk_done |=> !chk_done);

    p_allow_gated_r12: assert property (@(posedge clk) disable iff (!por_n)
        !chk_done |-> !chk_allow);

endmodule

bind sector_guard sector_guard_chk #(.N_SECT(N_SECT)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .nv_clr_n  (nv_clr_n),
    .hw_wp     (hw_wp),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .chk_busy  (chk_busy),
    .chk_done  (chk_done),
    .chk_allow (chk_allow),
    .qry_ack   (qry_ack),
    .qry_stat  (qry_stat),
    .prot_eff  (prot_eff),
    .lock_q    (lock_q)
);

// File: tb/sim_sector_guard.sv
`timescale 1ns/1ps
module sim_sector_guard;

    localparam int NS    = 128;
    localparam int LANES = 16;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        nv_clr_n = 1'b0;
    logic        hw_wp = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic        chk_valid = 1'b0;
    logic [1:0]  chk_kind = '0;
    logic [23:0] chk_addr = '0;
    logic        chk_busy, chk_done, chk_allow;
    logic        qry_valid = 1'b0;
    logic [23:0] qry_addr = '0;
    logic        qry_ack;
    logic [1:0]  qry_stat;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_prot [NS];
    bit m_lock [NS];

    always #2 clk = ~clk;

    sector_guard u0 (.*);

    function automatic logic [23:0] mk_addr(int s);
        return {1'($urandom), 7'(s), 16'($urandom)};
    endfunction

    function automatic logic [1:0] exp_stat(int s);
        return {m_lock[s], m_prot[s] | m_lock[s]};
    endfunction

    function automatic bit exp_chip_allow();
        for (int i = 0; i < NS; i++) if (m_prot[i] || m_lock[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_cmd(logic [2:0] op, int s, bit wp);
        case (op)
            3'd1: m_prot[s] = 1'b1;
            3'd2: if (!m_lock[s] && !wp) m_prot[s] = 1'b0;
            3'd3: for (int i = 0; i < NS; i++) m_prot[i] = 1'b1;
            3'd4: if (!wp) for (int i = 0; i < NS; i++) if (!m_lock[i]) m_prot[i] = 1'b0;
            3'd5: begin m_lock[s] = 1'b1; m_prot[s] = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic do_cmd(logic [2:0] op, int s, bit wp);
        @(negedge clk);
        hw_wp = wp; cmd_valid = 1'b1; cmd_op = op; cmd_addr = mk_addr(s);
        @(negedge clk);
        cmd_valid = 1'b0; hw_wp = 1'b0;
        model_cmd(op, s, wp);
    endtask

    task automatic do_qry(string req, int s);
        @(negedge clk);
        qry_valid = 1'b1; qry_addr = mk_addr(s);
        @(negedge clk);
        qry_valid = 1'b0;
        check(req, {31'd0, qry_ack}, 32'd1);
        check(req, {30'd0, qry_stat}, {30'd0, exp_stat(s)});
    endtask

    task automatic do_chk(string req, logic [1:0] kind, int s);
        int n = 0;
        bit ex;
        @(negedge clk);
        chk_valid = 1'b1; chk_kind = kind; chk_addr = mk_addr(s);
        ex = (kind == 2'd3) ? exp_chip_allow() : !(m_prot[s] || m_lock[s]);
        do begin
            @(negedge clk);
            chk_valid = 1'b0;
            n++;
        end while (!chk_done && n < 40);
        check(req, n, (kind == 2'd3) ? NS/LANES + 1 : 1);
        check(req, {31'd0, chk_allow}, {31'd0, ex});
        @(negedge clk);
        check("R12", {30'd0, chk_done, chk_allow}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) begin m_prot[i] = 1'b1; m_lock[i] = 1'b0; end
        repeat (3) @(negedge clk);
        por_n = 1'b1; nv_clr_n = 1'b1;
        @(negedge clk);
        // Reset state (R7, R12)
        check("R7", {31'd0, chk_busy}, 32'd0);
        check("R12", {30'd0, chk_done, chk_allow}, 32'd0);
        do_qry("R7", 0);
        do_qry("R7", NS-1);
        do_chk("R10", 2'd3, 0);

        // R4: global unprotect, then chip check allows
        do_cmd(3'd4, 0, 1'b0);
        do_qry("R4", 77);
        do_chk("R10", 2'd3, 0);
        do_chk("R9", 2'd0, 40);

        // R2 / R1: one sector protected, neighbours untouched
        do_cmd(3'd1, 40, 1'b0);
        do_qry("R1", 40);
        do_qry("R1", 39);
        do_qry("R1", 41);
        do_chk("R9", 2'd1, 40);
        do_chk("R9", 2'd2, 41);
        do_chk("R10", 2'd3, 5);
        do_cmd(3'd0, 40, 1'b0);
        do_cmd(3'd7, 41, 1'b0);
        do_qry("R2", 40);
        do_qry("R2", 41);

        // R5: lockdown survives global unprotect and por
        do_cmd(3'd5, 5, 1'b0);
        do_cmd(3'd4, 0, 1'b0);
        do_qry("R4", 5);
        do_qry("R4", 40);
        do_cmd(3'd2, 5, 1'b0);
        do_qry("R5", 5);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        for (int i = 0; i < NS; i++) m_prot[i] = 1'b1;
        do_qry("R7", 5);
        do_qry("R7", 6);

        // R6: write-protect freezes unprotect, honours protect
        do_cmd(3'd4, 0, 1'b1);
        do_qry("R6", 90);
        do_cmd(3'd2, 90, 1'b1);
        do_qry("R6", 90);
        do_cmd(3'd4, 0, 1'b0);
        do_cmd(3'd1, 90, 1'b1);
        do_qry("R6", 90);
        do_cmd(3'd3, 0, 1'b1);
        do_qry("R3", 33);

        // R11: command and check during a chip scan are ignored
        do_cmd(3'd4, 0, 1'b0);
        do_cmd(3'd1, 20, 1'b0);
        @(negedge clk);
        chk_valid = 1'b1; chk_kind = 2'd3; chk_addr = '0;
        @(negedge clk);
        chk_valid = 1'b0;
        check("R11", {31'd0, chk_busy}, 32'd1);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = mk_addr(20);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_valid = 1'b1; chk_kind = 2'd0; chk_addr = mk_addr(21);
        @(negedge clk);
        chk_valid = 1'b0;
        while (!chk_done) @(negedge clk);
        check("R11", {31'd0, chk_allow}, 32'd0);
        repeat (4) begin
            @(negedge clk);
            check("R11", {31'd0, chk_done}, 32'd0);
        end
        do_qry("R11", 20);

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            int s = int'($urandom_range(NS-1, 0));
            int r = int'($urandom_range(31, 0));
            logic [2:0] op;
            if (r == 0)       op = 3'd5;
            else if (r < 4)   op = 3'd3;
            else if (r < 8)   op = 3'd4;
            else if (r < 20)  op = 3'd2;
            else              op = 3'd1;
            do_cmd(op, s, 1'($urandom_range(3, 0) == 0));
            do_qry("R2", s);
            do_qry("R1", int'($urandom_range(NS-1, 0)));
            if (it % 8 == 0) do_chk("R9", 2'($urandom_range(2, 0)), s);
            if (it % 50 == 0) do_chk("R10", 2'd3, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule